// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Load/Store Unit

This block connects a simple processor core to a small data memory that is addressed one byte at a time. For each access it adds a sign-extended 16-bit displacement to a 32-bit base value to form the effective address. It then checks that address against the alignment rule for the requested access width. Word, halfword and byte reads and writes are carried out against an internal byte store, with the most significant byte of every multi-byte value placed at the lowest address.

Reads are combinational: the core presents base, displacement, width and sign mode, and the right-justified, extended result appears in the same cycle. Writes are committed on the rising clock edge and touch only the byte lanes that the width and address select. A misaligned access of any width raises a flag. A misaligned store changes no byte, and a misaligned load returns zero. The store is split into four lane banks of parameterised total depth, and the effective address wraps modulo that depth.

Top module: `bemem_unit`

## Requirements
- R1: `ea_o` equals `base_i` plus `offs_i` sign-extended to 32 bits, modulo 2^32. Any carry out of bit 31 is dropped, so the displacement reaches from -32768 to +32767 around the base.
- R2: Each address selects one 8-bit location. The location used is the effective address modulo DEPTH, so distinct byte addresses within a word reach distinct bytes.
- R3: Byte order is big-endian. After word 0x12345678 is written at address A, A holds 0x12 and A+3 holds 0x78, and an unsigned halfword read at A returns 0x00001234.
- R4: `size_i` encodes 00 = byte, 01 = halfword, 1x = word. A word access with `ea_o[1:0]` nonzero, or a halfword access with `ea_o[0]` set, drives `misalign_o` high in the same cycle. Byte accesses are never flagged.
- R5: A flagged store modifies no byte of memory, and a flagged load returns 0 on `rdata_o`.
- R6: A byte store writes `wdata_i[7:0]` to its one byte. A halfword store writes `wdata_i[15:0]` to its two bytes. All other bytes of the word are left unchanged.
- R7: Byte and halfword loads are right-justified. With `uns_i` = 1 the upper bits are zero, and with `uns_i` = 0 they copy the loaded value's top bit.
- R8: `rdata_o` follows the address and memory contents combinationally. A store becomes visible only after the rising clock edge that commits it.
- R9: While `rst_n` is low every byte of memory is cleared to zero. A load after reset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears memory |
| base_i | input | 32 | Base register value |
| offs_i | input | 16 | Signed two's-complement displacement |
| size_i | input | 2 | Access width: 00 byte, 01 halfword, 1x word |
| uns_i | input | 1 | 1 selects zero extension, 0 sign extension for narrow loads |
| wr_i | input | 1 | 1 requests a store this cycle, 0 a load |
| wdata_i | input | 32 | Store data, right-justified for narrow stores |
| rdata_o | output | 32 | Load result, extended per `uns_i` |
| misalign_o | output | 1 | Access address violates the alignment rule for `size_i` |
| ea_o | output | 32 | Effective address |

## Verification
The hardest situation to see from the ports is a rejected store, because a misaligned write leaves nothing behind that the same access can show. The stimulus first fills a word with known bytes through narrow stores. It then issues word and halfword stores at odd and half-odd addresses, and after each one reads the whole word back aligned to prove no lane moved. Address wrap is reached by picking base and displacement pairs whose sum carries out of bit 31 or cancels to zero. Lane isolation is reached by interleaving byte and halfword stores into the same word and reading it at every width and sign mode.

// File: rtl/bemem_pkg.sv
package bemem_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORDX = 2'b11
   } acc_size_e;

   typedef logic [7:0] byte_t;

   function automatic logic size_is_word(acc_size_e s);
      return s[1];
   endfunction

endpackage

// File: rtl/bemem_agen.sv
module bemem_agen
   import bemem_pkg::*;
#(
   parameter int AW = 32,
   parameter int OW = 16
) (
   input  logic [AW-1:0] base_i,
   input  logic [OW-1:0] offs_i,
   input  acc_size_e     size_i,
   output logic [AW-1:0] ea_o,
   output logic          misalign_o
);

   localparam int EXTW = AW - OW;

   generate
      if (OW > AW || OW < 2) begin : g_bad_ow
         $error("bemem_agen: offset width must be 2..AW");
      end
   endgenerate

   logic [AW-1:0] offs_sx;

   generate
      if (EXTW > 0) begin : g_sext
         assign offs_sx = {{EXTW{offs_i[OW-1]}}, offs_i};
      end else begin : g_noext
         assign offs_sx = offs_i;
      end
   endgenerate

   assign ea_o = base_i + offs_sx;

   always_comb begin
      unique case (size_i)
         SZ_BYTE: misalign_o = 1'b0;
         SZ_HALF: misalign_o = ea_o[0];
         default: misalign_o = |ea_o[1:0];
      endcase
   end

endmodule

// File: rtl/bemem_lane.sv
module bemem_lane
   import bemem_pkg::*;
#(
   parameter int DW = 32,
   localparam int LANES = DW / 8,
   localparam int OB = $clog2(LANES)
) (
   input  acc_size_e         size_i,
   input  logic [OB-1:0]     ofs_i,
   input  logic              wr_i,
   input  logic              uns_i,
   input  logic              misalign_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [DW-1:0]     rword_i,
   output logic [LANES-1:0]  lane_we_o,
   output byte_t [LANES-1:0] lane_wd_o,
   output logic [DW-1:0]     rdata_o
);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("bemem_lane: only a 32-bit word with four byte lanes is supported");
      end
   endgenerate

   byte_t rb [LANES];

   // lane k is the byte at word offset k; offset 0 is the most significant byte
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic hit;

      assign rb[k] = rword_i[DW-1-8*k -: 8];

      always_comb begin
         unique case (size_i)
            SZ_BYTE: hit = (ofs_i == OB'(k));
            SZ_HALF: hit = (ofs_i[OB-1] == ((k / 2) != 0));
            default: hit = 1'b1;
         endcase
      end

      assign lane_we_o[k] = wr_i & ~misalign_i & hit;

      always_comb begin
         unique case (size_i)
            SZ_BYTE: lane_wd_o[k] = wdata_i[7:0];
            SZ_HALF: lane_wd_o[k] = ((k % 2) == 0) ? wdata_i[15:8] : wdata_i[7:0];
            default: lane_wd_o[k] = wdata_i[DW-1-8*k -: 8];
         endcase
      end
   end

   byte_t       bsel;
   logic [15:0] hsel;

   assign bsel = rb[ofs_i];
   assign hsel = ofs_i[OB-1] ? {rb[2], rb[3]} : {rb[0], rb[1]};

   always_comb begin
      if (misalign_i) begin
         rdata_o = '0;
      end else begin
         unique case (size_i)
            SZ_BYTE: rdata_o = uns_i ? {{(DW-8){1'b0}}, bsel}
                                     : {{(DW-8){bsel[7]}}, bsel};
            SZ_HALF: rdata_o = uns_i ? {{(DW-16){1'b0}}, hsel}
                                     : {{(DW-16){hsel[15]}}, hsel};
            default: rdata_o = rword_i;
         endcase
      end
   end

endmodule

// File: rtl/bemem_array.sv
module bemem_array
   import bemem_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int DW = 32,
   localparam int LANES = DW / 8,
   localparam int WORDS = DEPTH / LANES,
   localparam int IW = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     idx_i,
   input  logic [LANES-1:0]  lane_we_i,
   input  byte_t [LANES-1:0] lane_wd_i,
   output logic [DW-1:0]     rword_o
);

   generate
      if (DEPTH < 2 * LANES || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bemem_array: DEPTH must be a power of two of at least two words");
      end
   endgenerate

   for (genvar k = 0; k < LANES; k++) begin : g_bank
      byte_t mem [WORDS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
               mem[i] <= '0;
            end
         end else if (lane_we_i[k]) begin
            mem[idx_i] <= lane_wd_i[k];
         end
      end

      assign rword_o[DW-1-8*k -: 8] = mem[idx_i];
   end

endmodule

// File: rtl/bemem_unit.sv
module bemem_unit
   import bemem_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int AW = 32,
   parameter int OW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base_i,
   input  logic [OW-1:0] offs_i,
   input  logic [1:0]    size_i,
   input  logic          uns_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          misalign_o,
   output logic [AW-1:0] ea_o
);

   localparam int LANES = DW / 8;
   localparam int OB = $clog2(LANES);
   localparam int WORDS = DEPTH / LANES;
   localparam int IW = $clog2(WORDS);

   generate
      if (AW < IW + OB) begin : g_bad_aw
         $error("bemem_unit: address width too small for DEPTH");
      end
   endgenerate

   acc_size_e         size_e;
   logic [LANES-1:0]  lane_we;
   byte_t [LANES-1:0] lane_wd;
   logic [DW-1:0]     rword;

   assign size_e = acc_size_e'(size_i);

   bemem_agen #(.AW(AW), .OW(OW)) u_agen (
      .base_i     (base_i),
      .offs_i     (offs_i),
      .size_i     (size_e),
      .ea_o       (ea_o),
      .misalign_o (misalign_o)
   );

   bemem_lane #(.DW(DW)) u_lane (
      .size_i     (size_e),
      .ofs_i      (ea_o[OB-1:0]),
      .wr_i       (wr_i),
      .uns_i      (uns_i),
      .misalign_i (misalign_o),
      .wdata_i    (wdata_i),
      .rword_i    (rword),
      .lane_we_o  (lane_we),
      .lane_wd_o  (lane_wd),
      .rdata_o    (rdata_o)
   );

   bemem_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_i     (ea_o[IW+OB-1:OB]),
      .lane_we_i (lane_we),
      .lane_wd_i (lane_wd),
      .rword_o   (rword)
   );

endmodule

// File: rtl/bemem_chk.sv
module bemem_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  size_i,
   input logic        uns_i,
   input logic        wr_i,
   input logic [31:0] wdata_i,
   input logic [31:0] rdata_o,
   input logic        misalign_o,
   input logic [31:0] ea_o,
   input logic [3:0]  lane_we
);

   // R4
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i[1] && ea_o[1:0] != 2'b00) |-> misalign_o);

   // R4
   half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b01 && ea_o[0]) |-> misalign_o);

   // R4
   byte_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b00) |-> !misalign_o);

   // R5
   mis_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (lane_we == 4'b0000));

   // R5
   mis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (rdata_o == 32'h0));

   // R6
   byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && size_i == 2'b00) |-> ($countones(lane_we) == 1));

   // R6
   half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && size_i == 2'b01 && !misalign_o) |-> ($countones(lane_we) == 2));

   // R6
   word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && size_i[1] && !misalign_o) |-> (lane_we == 4'b1111));

   // R7
   zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b00 && uns_i) |-> (rdata_o[31:8] == 24'h0));

   // R7
   sext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b00 && !uns_i) |-> (rdata_o[31:8] == {24{rdata_o[7]}}));

   // R7
   zext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'b01 && uns_i) |-> (rdata_o[31:16] == 16'h0));

   // R8
   store_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && size_i[1] && !misalign_o) |=>
         (!($stable(ea_o) && size_i[1]) || rdata_o == $past(wdata_i)));

endmodule

bind bemem_unit bemem_chk i_bemem_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .size_i     (size_i),
   .uns_i      (uns_i),
   .wr_i       (wr_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .misalign_o (misalign_o),
   .ea_o       (ea_o),
   .lane_we    (lane_we)
);

// File: tb/test_bemem_unit.sv
`timescale 1ns/1ps
module test_bemem_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_i = '0;
   logic [15:0] offs_i = '0;
   logic [1:0]  size_i = 2'b10;
   logic        uns_i = 1'b1;
   logic        wr_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        misalign_o;
   logic [31:0] ea_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bemem_unit i_bemem_unit (
      .clk(clk), .rst_n(rst_n), .base_i(base_i), .offs_i(offs_i),
      .size_i(size_i), .uns_i(uns_i), .wr_i(wr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .misalign_o(misalign_o), .ea_o(ea_o)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic        uns;
      logic [31:0] base;
      logic [15:0] offs;
      logic [31:0] wd;
      logic [31:0] erd;
      logic        emis;
      logic [31:0] eea;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t TBL [NV] = '{
      {1'b1, 2'd2, 1'b1, 32'h00001000, 16'h0000, 32'h12345678, 32'h00000000, 1'b0, 32'h00001000},
      {1'b0, 2'd1, 1'b1, 32'h00001000, 16'h0000, 32'h0,        32'h00001234, 1'b0, 32'h00001000},
      {1'b0, 2'd1, 1'b1, 32'h00001004, 16'hFFFE, 32'h0,        32'h00005678, 1'b0, 32'h00001002},
      {1'b0, 2'd0, 1'b1, 32'h00001000, 16'h0003, 32'h0,        32'h00000078, 1'b0, 32'h00001003},
      {1'b1, 2'd0, 1'b1, 32'h00001000, 16'h0001, 32'h000000F0, 32'h00000000, 1'b0, 32'h00001001},
      {1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0000, 32'h0,        32'h12F05678, 1'b0, 32'h00001000},
      {1'b0, 2'd0, 1'b0, 32'h00001000, 16'h0001, 32'h0,        32'hFFFFFFF0, 1'b0, 32'h00001001},
      {1'b0, 2'd0, 1'b1, 32'h00001002, 16'hFFFF, 32'h0,        32'h000000F0, 1'b0, 32'h00001001},
      {1'b1, 2'd1, 1'b0, 32'h00001000, 16'h0002, 32'h00009ABC, 32'h00000000, 1'b0, 32'h00001002},
      {1'b0, 2'd1, 1'b0, 32'h00001000, 16'h0002, 32'h0,        32'hFFFF9ABC, 1'b0, 32'h00001002},
      {1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0002, 32'h0,        32'h00000000, 1'b1, 32'h00001002},
      {1'b1, 2'd2, 1'b1, 32'h00001000, 16'h0001, 32'hDEADBEEF, 32'h00000000, 1'b1, 32'h00001001},
      {1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0000, 32'h0,        32'h12F09ABC, 1'b0, 32'h00001000},
      {1'b0, 2'd1, 1'b1, 32'h00001000, 16'h0001, 32'h0,        32'h00000000, 1'b1, 32'h00001001},
      {1'b1, 2'd1, 1'b1, 32'h00001000, 16'h0003, 32'h00001111, 32'h00000000, 1'b1, 32'h00001003},
      {1'b0, 2'd3, 1'b0, 32'h00001000, 16'h0000, 32'h0,        32'h12F09ABC, 1'b0, 32'h00001000},
      {1'b0, 2'd2, 1'b1, 32'hFFFFFFFC, 16'h0004, 32'h0,        32'h12F09ABC, 1'b0, 32'h00000000},
      {1'b0, 2'd2, 1'b1, 32'h00008000, 16'h8000, 32'h0,        32'h12F09ABC, 1'b0, 32'h00000000},
      {1'b0, 2'd0, 1'b1, 32'h00000000, 16'h7FFF, 32'h0,        32'h00000000, 1'b0, 32'h00007FFF},
      {1'b0, 2'd1, 1'b0, 32'h00001000, 16'h0000, 32'h0,        32'h000012F0, 1'b0, 32'h00001000}
   };

   string tag [NV];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [1:0] sz, input logic uns,
                        input logic [31:0] base, input logic [15:0] offs,
                        input logic [31:0] wd);
      @(negedge clk);
      wr_i = wr; size_i = sz; uns_i = uns;
      base_i = base; offs_i = offs; wdata_i = wd;
      #2;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tag = '{"R3", "R3", "R1", "R2", "R6", "R6", "R7", "R7", "R6", "R7",
              "R5", "R5", "R5", "R4", "R5", "R5", "R1", "R1", "R2", "R7"};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: memory starts cleared
      drive(1'b0, 2'd2, 1'b1, 32'h00000040, 16'h0000, 32'h0);
      check("R9", "reset word", rdata_o, 32'h0);
      check("R9", "reset flag", {31'b0, misalign_o}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].wr, TBL[i].sz, TBL[i].uns, TBL[i].base, TBL[i].offs, TBL[i].wd);
         check(tag[i], $sformatf("vec%0d flag", i), {31'b0, misalign_o}, {31'b0, TBL[i].emis});
         check("R1", $sformatf("vec%0d ea", i), ea_o, TBL[i].eea);
         if (!TBL[i].wr) begin
            check(tag[i], $sformatf("vec%0d rdata", i), rdata_o, TBL[i].erd);
         end
      end

      // R8: read follows the address within the cycle
      drive(1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0000, 32'h0);
      check("R8", "comb read A", rdata_o, 32'h12F09ABC);
      offs_i = 16'h0008;
      #1;
      check("R8", "comb read B", rdata_o, 32'h00000000);

      // R8: store is not visible before its edge, visible after
      drive(1'b1, 2'd2, 1'b1, 32'h00001000, 16'h0008, 32'hCAFEF00D);
      check("R8", "pre-edge", rdata_o, 32'h00000000);
      drive(1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0008, 32'h0);
      check("R8", "post-edge", rdata_o, 32'hCAFEF00D);

      // R2: byte at offset 2 of the new word
      drive(1'b0, 2'd0, 1'b1, 32'h00001000, 16'h000A, 32'h0);
      check("R2", "byte lane 2", rdata_o, 32'h000000F0);

      // R9: reset clears written data
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0000, 32'h0);
      check("R9", "cleared word", rdata_o, 32'h0);
      drive(1'b0, 2'd2, 1'b1, 32'h00001000, 16'h0008, 32'h0);
      check("R9", "cleared word 2", rdata_o, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule